// File: doc/BRIEF.md
# Banked Nonvolatile-Style Register Store

This block holds the saved settings behind a digitally controlled potentiometer. It has sixteen byte-wide registers in four banks of four, built from flops. The registers stand in for nonvolatile cells. A command decoder in front of the block turns bus transactions into single-cycle commands, offered over a valid/ready handshake. Each command is one of four operations:

- read any register;
- write any register;
- store the current wiper value into a register;
- select a register for loading into the wiper.

The two wiper operations may only name bank 0.

A write is not committed when its command is accepted. The block keeps the address and data as a pending write. When the decoder reports the bus stop condition, the block starts a long internal write cycle and raises `busy`. The register changes only when that window closes. While `busy` is high the block deasserts `cmd_ready`, which is the back-pressure rule: the decoder holds its command and withholds its address acknowledge. A low level on the write-protect input blocks any write at acceptance. The register holding the power-up default (bank 0, register 0) drives `recall_data` at all times, so the wiper register can load it after reset.

Top module: `nvreg_store`

## Requirements
- R1: After reset all registers hold `RESET_VAL`, `busy` is 0, `cmd_ready` is 1, the read address is 0, and `rd_data` equals `RESET_VAL`.
- R2: An accepted read command (`cmd_op` = 0) may name any address. In the cycle after acceptance, `rd_data` shows that register combinationally. `rd_data` changes only after an accepted command or at the end of a write cycle.
- R3: An accepted write command (`cmd_op` = 1) with `wp_n` high becomes pending. The cycle after `bus_stop` is sampled with a write pending, `busy` rises and stays high for exactly `WR_CYCLES` cycles.
- R4: A pending or running write leaves the register unchanged. The new value is stored on the edge at which `busy` falls.
- R5: `cmd_ready` is low whenever `busy` is high. A command offered while busy has no effect.
- R6: A write or store command accepted while `wp_n` is low is dropped. A later stop raises no `busy`, and no register changes.
- R7: A store-wiper command (`cmd_op` = 2, data on `cmd_data`) acts like a write only when the bank field `cmd_addr[3:2]` is 0. For any other bank it is ignored.
- R8: A load-wiper command (`cmd_op` = 3) moves the read address only when `cmd_addr[3:2]` is 0. For any other bank the read address is unchanged.
- R9: `recall_data` always equals bank 0, register 0 (address 0).
- R10: A `bus_stop` with no pending write does not raise `busy`.
- R11: A second accepted write before the stop replaces the first. Only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (low while busy) |
| cmd_op | input | 2 | 0 read, 1 write, 2 store wiper, 3 load wiper |
| cmd_addr | input | 4 | Bank in [3:2], register in [1:0] |
| cmd_data | input | 8 | Write or wiper data |
| bus_stop | input | 1 | One-cycle pulse: bus stop condition seen |
| wp_n | input | 1 | Write enable; low blocks writes |
| busy | output | 1 | Internal write cycle running |
| rd_data | output | 8 | Contents of the selected register |
| recall_data | output | 8 | Power-up default value for the wiper |

## Verification
A pending-write fault, such as a lost address or a stale replaced value, appears only at a later read. It shows up in `rd_data` the cycle after that read is accepted. A timer fault appears at `busy` within `WR_CYCLES + 1` cycles of the stop, as a window of the wrong length or a missing window. A fault in bank gating or write protect corrupts a register that the sweep reads back straight after the blocked command. Faults in the read-address register or the array mux show up as a wrong `rd_data` on the next read in the sweep.

// File: rtl/nvreg_pkg.sv
package nvreg_pkg;
  typedef enum logic [1:0] {
    OP_READ        = 2'd0,
    OP_WRITE       = 2'd1,
    OP_STORE_WIPER = 2'd2,
    OP_LOAD_WIPER  = 2'd3
  } nv_op_e;
endpackage

// File: rtl/nvreg_cmd.sv
module nvreg_cmd
  import nvreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wp_n,
  input  logic              stop,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic              start
);
  nv_op_e op_e;
  logic   bank0;
  logic   pend_valid;
  logic   take_wr;

  assign op_e    = nv_op_e'(op);
  assign bank0   = (addr[ADDR_W-1 -: BANK_W] == '0);
  assign take_wr = accept && wp_n &&
                   ((op_e == OP_WRITE) || ((op_e == OP_STORE_WIPER) && bank0));
  assign start   = stop && pend_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr    <= '0;
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
    end else begin
      if (accept && ((op_e == OP_READ) || ((op_e == OP_LOAD_WIPER) && bank0)))
        rd_addr <= addr;
      if (take_wr) begin
        pend_valid <= 1'b1;
        pend_addr  <= addr;
        pend_data  <= data;
      end else if (start) begin
        pend_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvreg_timer.sv
module nvreg_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nvreg_array.sv
module nvreg_array #(
  parameter int          ENTRIES   = 16,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  RESET_VAL = 8'h80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [$clog2(ENTRIES)-1:0] raddr,
  output logic [DATA_W-1:0]          rdata,
  output logic [DATA_W-1:0]          entry0
);
  logic [DATA_W-1:0] mem [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= DATA_W'(RESET_VAL);
      else if (we && (int'(waddr) == g))
        mem[g] <= wdata;
    end
  end

  assign rdata  = mem[raddr];
  assign entry0 = mem[0];
endmodule

// File: rtl/nvreg_store.sv
module nvreg_store #(
  parameter int         BANKS         = 4,
  parameter int         REGS_PER_BANK = 4,
  parameter int         DATA_W        = 8,
  parameter int         WR_CYCLES     = 500000,
  parameter logic [7:0] RESET_VAL     = 8'h80,
  localparam int        ENTRIES       = BANKS * REGS_PER_BANK,
  localparam int        ADDR_W        = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              bus_stop,
  input  logic              wp_n,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] recall_data
);
  localparam int BANK_W = $clog2(BANKS);

  logic              accept;
  logic              start;
  logic              done;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  nvreg_cmd #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(cmd_op), .addr(cmd_addr),
    .data(cmd_data), .wp_n(wp_n), .stop(bus_stop), .busy(busy),
    .rd_addr(rd_addr), .pend_addr(pend_addr), .pend_data(pend_data), .start(start)
  );

  nvreg_timer #(.CYCLES(WR_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  nvreg_array #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) array_i (
    .clk(clk), .rst_n(rst_n), .we(done), .waddr(pend_addr), .wdata(pend_data),
    .raddr(rd_addr), .rdata(rd_data), .entry0(recall_data)
  );
endmodule

// File: rtl/nvreg_store_chk.sv
module nvreg_store_chk #(
  parameter int WR_CYCLES = 8,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bus_stop,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] recall_data
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  // R3: the write window lasts exactly WR_CYCLES cycles
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == WR_CYCLES));

  // R3, R10: a write window opens only after a stop
  p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  // R5: no command is taken while busy
  p_no_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |-> !cmd_ready);

  // R2: read data moves only after an accepted command or a write commit
  p_rd_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_ready) && !busy) |=> $stable(rd_data));

  // R9, R4: the recall value changes only at a commit
  p_recall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(recall_data));
endmodule

bind nvreg_store nvreg_store_chk #(.WR_CYCLES(WR_CYCLES), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_stop(bus_stop),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .rd_data(rd_data),
  .recall_data(recall_data)
);

// File: tb/nvreg_store_tb_top.sv
module nvreg_store_tb_top;
  localparam int         WRC  = 8;
  localparam logic [7:0] RVAL = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_addr = 4'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       bus_stop = 1'b0;
  logic       wp_n = 1'b1;
  logic       busy;
  logic [7:0] rd_data;
  logic [7:0] recall_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] model [16];
  int last_rd = 0;

  always #5 clk = ~clk;

  nvreg_store #(.WR_CYCLES(WRC), .RESET_VAL(RVAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .bus_stop(bus_stop), .wp_n(wp_n), .busy(busy), .rd_data(rd_data),
    .recall_data(recall_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int a);
    issue(2'd0, 4'(a), 8'h00);
    last_rd = a;
  endtask

  // pulse stop, then count busy cycles seen at negedges
  task automatic stop_count(output int n);
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) model[i] = RVAL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(rd_data == RVAL, "R1 rd_data", rd_data, RVAL);
    check(recall_data == RVAL, "R9 recall reset", recall_data, RVAL);

    // R2 read every address
    for (int i = 0; i < 16; i++) begin
      rd(i);
      check(rd_data == model[i], "R2 read sweep", rd_data, model[i]);
    end

    // R3 / R4 write sweep over all 16 registers
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) ^ 8'hC3);
      issue(2'd1, 4'(i), v);
      if (i == 4) begin
        rd(4);
        check(rd_data == model[4], "R4 pending not visible", rd_data, model[4]);
      end
      stop_count(n);
      check(n == WRC, "R3 busy length", n, WRC);
      model[i] = v;
      rd(i);
      check(rd_data == v, "R4 committed value", rd_data, v);
      check(recall_data == model[0], "R9 recall tracks entry 0", recall_data, model[0]);
    end

    // R6 write protect
    wp_n = 1'b0;
    issue(2'd1, 4'd5, 8'hEE);
    issue(2'd2, 4'd1, 8'hDD);
    wp_n = 1'b1;
    stop_count(n);
    check(n == 0, "R6 no busy", n, 0);
    rd(5);
    check(rd_data == model[5], "R6 reg5 unchanged", rd_data, model[5]);
    rd(1);
    check(rd_data == model[1], "R6 reg1 unchanged", rd_data, model[1]);

    // R7 store wiper, bank 0 and bank 2
    issue(2'd2, 4'd2, 8'h3C);
    stop_count(n);
    check(n == WRC, "R7 bank0 store busy", n, WRC);
    model[2] = 8'h3C;
    rd(2);
    check(rd_data == 8'h3C, "R7 bank0 store", rd_data, 8'h3C);
    issue(2'd2, 4'd9, 8'hA5);
    stop_count(n);
    check(n == 0, "R7 bank2 store no busy", n, 0);
    rd(9);
    check(rd_data == model[9], "R7 bank2 unchanged", rd_data, model[9]);

    // R8 load wiper selection
    issue(2'd3, 4'd3, 8'h00);
    last_rd = 3;
    check(rd_data == model[3], "R8 bank0 load", rd_data, model[3]);
    issue(2'd3, 4'd13, 8'h00);
    check(rd_data == model[3], "R8 bank3 load ignored", rd_data, model[3]);

    // R10 stop without pending write
    stop_count(n);
    check(n == 0, "R10 idle stop", n, 0);

    // R11 second write replaces first
    issue(2'd1, 4'd6, 8'h11);
    issue(2'd1, 4'd7, 8'h22);
    stop_count(n);
    check(n == WRC, "R11 single window", n, WRC);
    model[7] = 8'h22;
    rd(6);
    check(rd_data == model[6], "R11 first dropped", rd_data, model[6]);
    rd(7);
    check(rd_data == 8'h22, "R11 last committed", rd_data, 8'h22);

    // R5 commands offered while busy are not taken
    issue(2'd1, 4'd8, 8'h77);
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
    check(cmd_ready == 1'b0, "R5 ready low", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 4'd12;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    model[8] = 8'h77;
    check(rd_data == model[last_rd], "R5 busy read ignored", rd_data, model[last_rd]);
    rd(8);
    check(rd_data == 8'h77, "R5 write committed", rd_data, 8'h77);

    // R1 reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == RVAL, "R1 reset again", rd_data, RVAL);
    check(recall_data == RVAL, "R9 recall after reset", recall_data, RVAL);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule